// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits between the decode and execute stages of a five-stage in-order pipeline for a small eight-register machine. Each cycle it looks at two instruction words: the older one, which is about to execute, and the younger one, which has just been fetched and is being decoded. If the older instruction is a load and the younger one needs the loaded register before the value can be forwarded, the unit asks for a one-cycle stall. It holds the program counter and the fetch/decode latch, and it puts a no-operation word into the decode/execute latch in place of the younger instruction.

Which source fields of the younger instruction count depends on its opcode. Arithmetic, logic and compare-and-branch instructions read both source registers. Loads and stores only need their base-address register early, because store data can be forwarded later. Jump, halt and no-operation never cause a stall. A taken-branch flush arriving in the same cycle has priority over the holds, because the flush replaces the whole front end anyway.

Instruction fields the unit decodes: opcode in bits 24:22 (add=0, nand=1, lw=2, sw=3, beq=4, jalr=5, halt=6, noop=7), first source field in bits 21:19, second field in bits 18:16. The no-operation word is 0x01C00000.

Top module: `lu_hazard_top`

## Requirements
- R1: `stall` is 0 whenever the decode/execute word's opcode (bits 24:22) is not 2 (lw); the load's destination is its bits 18:16.
- R2: When the fetch/decode word's opcode is 0, 1 or 4, `stall` is 1 exactly when the load is present and either bits 21:19 or bits 18:16 of that word equal the load destination.
- R3: When the fetch/decode word's opcode is 2 or 3, `stall` is 1 exactly when the load is present and bits 21:19 equal the load destination; bits 18:16 have no effect.
- R4: When the fetch/decode word's opcode is 5, 6 or 7, `stall` is 0.
- R5: With `flush_taken` low, `pc_hold` and `ifid_hold` both equal `stall`.
- R6: `idex_bubble` is 1 when `stall` or `flush_taken` is 1, and `idex_instr_next` is then 0x01C00000; otherwise `idex_instr_next` equals `ifid_instr`.
- R7: With `flush_taken` high, `pc_hold` and `ifid_hold` are 0 whatever the hazard; `stall` still reports the raw hazard.
- R8: Bits 31:25 and 15:0 of both words have no effect on `stall`, `pc_hold`, `ifid_hold` or `idex_bubble`.
- R9: When the pipeline loads `idex_instr_next` into decode/execute and keeps the fetch/decode word while `ifid_hold` is high, a given load/consumer pair stalls for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_instr | input | 32 | Instruction word in the fetch/decode latch (younger) |
| idex_instr | input | 32 | Instruction word in the decode/execute latch (older) |
| flush_taken | input | 1 | Taken-branch flush this cycle |
| stall | output | 1 | Raw load-use hazard detected |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode word and its next-PC value |
| idex_bubble | output | 1 | Write a no-operation into decode/execute |
| idex_instr_next | output | 32 | Word to load into decode/execute next cycle |

## Verification
The assertions check on every input change that a stall only ever follows a load, that it never comes from a jump, halt or no-operation consumer, that a field match stands behind each stall for the opcode class in question, that the two holds agree and drop under a flush, and that a bubble always carries the no-operation word. Only the bench's scenarios can show that the detection is complete (no missed hazard across every opcode and register pairing), that ignored bits really have no effect, and that a stalled pair clears after one cycle once the bubble is fed back into the pipeline.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned REG_W   = 3;
  localparam int unsigned OPC_W   = 3;
  localparam int unsigned RB_LSB  = 16;
  localparam int unsigned RA_LSB  = RB_LSB + REG_W;
  localparam int unsigned OPC_LSB = RA_LSB + REG_W;
  localparam int unsigned FIELD_W = OPC_W + 2 * REG_W;
  localparam int unsigned NSRC    = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 3'd0,
    OPC_NAND = 3'd1,
    OPC_LOAD = 3'd2,
    OPC_STOR = 3'd3,
    OPC_BREQ = 3'd4,
    OPC_JUMP = 3'd5,
    OPC_STOP = 3'd6,
    OPC_IDLE = 3'd7
  } opcode_e;

  // How many source fields an instruction needs early
  typedef enum logic [1:0] {
    USE_NONE = 2'd0,
    USE_BASE = 2'd1,
    USE_BOTH = 2'd2
  } src_use_e;

  localparam logic [WORD_W-1:0] BUBBLE_WORD =
    WORD_W'(32'd7) << OPC_LSB;

  function automatic opcode_e fld_opcode(input logic [FIELD_W-1:0] f);
    return opcode_e'(f[FIELD_W-1 -: OPC_W]);
  endfunction

  function automatic logic [REG_W-1:0] fld_reg_a(input logic [FIELD_W-1:0] f);
    return f[2*REG_W-1 -: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] fld_reg_b(input logic [FIELD_W-1:0] f);
    return f[REG_W-1:0];
  endfunction

  function automatic src_use_e opcode_src_use(input opcode_e op);
    case (op)
      OPC_ADD, OPC_NAND, OPC_BREQ: return USE_BOTH;
      OPC_LOAD, OPC_STOR:          return USE_BASE;
      default:                     return USE_NONE;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] src_enable(input src_use_e u);
    case (u)
      USE_BOTH: return 2'b11;
      USE_BASE: return 2'b01;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/lu_instr_decode.sv
module lu_instr_decode
  import lu_hazard_pkg::*;
#(
  parameter int unsigned F_W = FIELD_W,
  parameter int unsigned R_W = REG_W
) (
  input  logic [F_W-1:0] fields,
  output opcode_e        opcode,
  output logic [R_W-1:0] reg_a,
  output logic [R_W-1:0] reg_b,
  output src_use_e       src_use,
  output logic           is_load
);

  always_comb begin
    opcode  = fld_opcode(fields);
    reg_a   = fld_reg_a(fields);
    reg_b   = fld_reg_b(fields);
    src_use = opcode_src_use(opcode);
    is_load = (opcode == OPC_LOAD);
  end

endmodule

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int unsigned R_W    = 3,
  parameter int unsigned N_SRC  = 2
) (
  input  logic [N_SRC-1:0][R_W-1:0] src_reg,
  input  logic [N_SRC-1:0]          src_en,
  input  logic [R_W-1:0]            dest_reg,
  output logic [N_SRC-1:0]          per_hit,
  output logic                      any_hit
);

  for (genvar s = 0; s < N_SRC; s++) begin : g_cmp
    assign per_hit[s] = src_en[s] && (src_reg[s] == dest_reg);
  end

  assign any_hit = |per_hit;

  // R3: a disabled source field never reports a match
  always_comb begin
    a_r3_disabled_src_quiet: assert ((per_hit & ~src_en) == '0)
      else $error("disabled source field matched");
  end

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl #(
  parameter int unsigned        W_W    = 32,
  parameter logic [W_W-1:0]     BUBBLE = '0
) (
  input  logic           prod_is_load,
  input  logic           src_hit,
  input  logic           flush_taken,
  input  logic [W_W-1:0] ifid_word,
  output logic           stall,
  output logic           pc_hold,
  output logic           ifid_hold,
  output logic           idex_bubble,
  output logic [W_W-1:0] idex_next
);

  logic hold_req;

  always_comb begin
    stall       = prod_is_load && src_hit;
    hold_req    = stall && !flush_taken;
    pc_hold     = hold_req;
    ifid_hold   = hold_req;
    idex_bubble = stall || flush_taken;
    idex_next   = idex_bubble ? BUBBLE : ifid_word;
  end

  always_comb begin
    // R5: both front-end holds move together
    a_r5_holds_agree: assert (pc_hold == ifid_hold)
      else $error("pc_hold and ifid_hold differ");
    // R7: a flush never leaves a hold asserted
    a_r7_flush_no_hold: assert (!(flush_taken && (pc_hold || ifid_hold)))
      else $error("hold asserted during flush");
    // R6: a bubble always carries the no-operation word
    a_r6_bubble_word: assert (!idex_bubble || idex_next == BUBBLE)
      else $error("bubble without no-operation word");
    // R6: a hold always comes with a bubble
    a_r6_hold_implies_bubble: assert (!pc_hold || idex_bubble)
      else $error("hold without bubble");
  end

endmodule

// File: rtl/lu_hazard_top.sv
module lu_hazard_top
  import lu_hazard_pkg::*;
#(
  parameter int unsigned W_W = WORD_W
) (
  input  logic [W_W-1:0] ifid_instr,
  input  logic [W_W-1:0] idex_instr,
  input  logic           flush_taken,
  output logic           stall,
  output logic           pc_hold,
  output logic           ifid_hold,
  output logic           idex_bubble,
  output logic [W_W-1:0] idex_instr_next
);

  localparam int unsigned FLD_HI = OPC_LSB + OPC_W - 1;

  // Older (producer) and younger (consumer) decoded fields
  opcode_e           prod_opc,  cons_opc;
  logic [REG_W-1:0]  prod_ra,   prod_rb;
  logic [REG_W-1:0]  cons_ra,   cons_rb;
  src_use_e          prod_use,  cons_use;
  logic              prod_load, cons_load;

  logic [NSRC-1:0][REG_W-1:0] cons_src;
  logic [NSRC-1:0]            cons_en;
  logic [NSRC-1:0]            src_hits;
  logic                       any_src_hit;

  logic unused_bits;
  assign unused_bits = ^{ifid_instr[W_W-1:FLD_HI+1], ifid_instr[RB_LSB-1:0],
                         idex_instr[W_W-1:FLD_HI+1], idex_instr[RB_LSB-1:0],
                         prod_ra, prod_use, cons_load};

  lu_instr_decode #(.F_W(FIELD_W), .R_W(REG_W)) u_dec_prod (
    .fields  (idex_instr[FLD_HI:RB_LSB]),
    .opcode  (prod_opc),
    .reg_a   (prod_ra),
    .reg_b   (prod_rb),
    .src_use (prod_use),
    .is_load (prod_load)
  );

  lu_instr_decode #(.F_W(FIELD_W), .R_W(REG_W)) u_dec_cons (
    .fields  (ifid_instr[FLD_HI:RB_LSB]),
    .opcode  (cons_opc),
    .reg_a   (cons_ra),
    .reg_b   (cons_rb),
    .src_use (cons_use),
    .is_load (cons_load)
  );

  // Source slot 0 is the base/first field, slot 1 the second field
  always_comb begin
    cons_src[0] = cons_ra;
    cons_src[1] = cons_rb;
    cons_en     = src_enable(cons_use);
  end

  lu_src_match #(.R_W(REG_W), .N_SRC(NSRC)) u_match (
    .src_reg  (cons_src),
    .src_en   (cons_en),
    .dest_reg (prod_rb),
    .per_hit  (src_hits),
    .any_hit  (any_src_hit)
  );

  lu_stall_ctrl #(.W_W(W_W), .BUBBLE(BUBBLE_WORD)) u_ctrl (
    .prod_is_load (prod_load),
    .src_hit      (any_src_hit),
    .flush_taken  (flush_taken),
    .ifid_word    (ifid_instr),
    .stall        (stall),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble),
    .idex_next    (idex_instr_next)
  );

  always_comb begin
    // R1: a stall only follows a load in decode/execute
    a_r1_only_after_load: assert (!stall || prod_opc == OPC_LOAD)
      else $error("stall without load producer");
    // R4: jump, halt and no-operation never stall
    a_r4_quiet_consumers: assert (!stall || !(cons_opc inside {OPC_JUMP, OPC_STOP, OPC_IDLE}))
      else $error("stall from non-reading consumer");
    // R3: base-only consumers stall only on a first-field match
    a_r3_base_match: assert (!(stall && cons_opc inside {OPC_LOAD, OPC_STOR}) || cons_ra == prod_rb)
      else $error("base-only consumer stalled without base match");
    // R2: two-source consumers stall only on some field match
    a_r2_pair_match: assert (!(stall && cons_opc inside {OPC_ADD, OPC_NAND, OPC_BREQ})
                             || cons_ra == prod_rb || cons_rb == prod_rb)
      else $error("two-source consumer stalled without match");
  end

endmodule

// File: tb/tb_lu_hazard_top.sv
module tb_lu_hazard_top;

  localparam logic [31:0] NOOP_W = 32'h01C0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ifid_q, idex_q;
  logic        flush_q;
  logic        stall, pc_hold, ifid_hold, idex_bubble;
  logic [31:0] idex_instr_next;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lu_hazard_top dut (
    .ifid_instr      (ifid_q),
    .idex_instr      (idex_q),
    .flush_taken     (flush_q),
    .stall           (stall),
    .pc_hold         (pc_hold),
    .ifid_hold       (ifid_hold),
    .idex_bubble     (idex_bubble),
    .idex_instr_next (idex_instr_next)
  );

  function automatic logic [31:0] mk(input logic [6:0] hi, input logic [2:0] op,
                                     input logic [2:0] a, input logic [2:0] b,
                                     input logic [15:0] off);
    return {hi, op, a, b, off};
  endfunction

  // Independent reference: written as a table of reads per consumer opcode
  function automatic logic ref_stall(input logic [31:0] younger, input logic [31:0] older);
    logic [2:0] d;
    logic reads_a, reads_b;
    d = older[18:16];
    reads_a = (younger[24:22] <= 3'd4);
    reads_b = (younger[24:22] == 3'd0) || (younger[24:22] == 3'd1) || (younger[24:22] == 3'd4);
    if (older[24:22] != 3'd2) return 1'b0;
    return (reads_a && younger[21:19] == d) || (reads_b && younger[18:16] == d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (ifid=%h idex=%h flush=%b)",
               req, act, exp, ifid_q, idex_q, flush_q);
    end
  endtask

  function automatic string stall_req(input logic [31:0] y, input logic [31:0] o);
    if (o[24:22] != 3'd2) return "R1";
    if (y[24:22] inside {3'd0, 3'd1, 3'd4}) return "R2";
    if (y[24:22] inside {3'd2, 3'd3}) return "R3";
    return "R4";
  endfunction

  task automatic check_all(input string tag);
    logic es, eh, eb;
    es = ref_stall(ifid_q, idex_q);
    eh = es && !flush_q;
    eb = es || flush_q;
    chk({tag, stall_req(ifid_q, idex_q)}, {31'd0, stall}, {31'd0, es});
    chk({tag, flush_q ? "R7" : "R5"}, {30'd0, pc_hold, ifid_hold}, {30'd0, eh, eh});
    chk({tag, "R6"}, {31'd0, idex_bubble}, {31'd0, eb});
    chk({tag, "R6"}, idex_instr_next, eb ? NOOP_W : ifid_q);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    ifid_q = NOOP_W; idex_q = NOOP_W; flush_q = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset stall", {31'd0, stall}, 32'd0);
    chk("R5 reset hold", {30'd0, pc_hold, ifid_hold}, 32'd0);
    chk("R6 reset next", idex_instr_next, NOOP_W);
  endtask

  // R1 R2 R3 R4 R5 R6 R7: every opcode and field pairing, flush on and off
  task automatic t_sweep();
    for (int fl = 0; fl < 2; fl++)
      for (int po = 0; po < 8; po++)
        for (int pd = 0; pd < 8; pd++)
          for (int co = 0; co < 8; co++)
            for (int ca = 0; ca < 8; ca++)
              for (int cb = 0; cb < 8; cb++) begin
                flush_q = fl[0];
                idex_q  = mk(7'd0, po[2:0], 3'd5, pd[2:0], 16'h0010);
                ifid_q  = mk(7'd0, co[2:0], ca[2:0], cb[2:0], 16'hFFF0);
                #1;
                check_all("sweep ");
              end
  endtask

  // R8: upper bits and offsets do not change detection
  task automatic t_ignored_bits();
    logic [15:0] offs [4] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0003};
    logic [6:0]  his  [4] = '{7'h00, 7'h7F, 7'h55, 7'h2A};
    for (int i = 0; i < 4; i++) begin
      flush_q = 1'b0;
      idex_q = mk(his[i], 3'd2, 3'd1, 3'd6, offs[i]);
      ifid_q = mk(his[3-i], 3'd0, 3'd6, 3'd2, offs[3-i]);
      #1;
      chk("R8 stall hit", {31'd0, stall}, 32'd1);
      chk("R8 hold hit", {31'd0, pc_hold}, 32'd1);
      ifid_q = mk(his[i], 3'd7, 3'd6, 3'd6, offs[i]);
      #1;
      chk("R8 stall none", {31'd0, stall}, 32'd0);
      chk("R8 bubble none", {31'd0, idex_bubble}, 32'd0);
      idex_q = mk(his[3-i], 3'd6, 3'd1, 3'd6, offs[i]);
      ifid_q = mk(his[i], 3'd1, 3'd6, 3'd6, offs[3-i]);
      #1;
      chk("R8 stall nonload", {31'd0, stall}, 32'd0);
    end
  endtask

  // R9: with the bubble fed back and the latch held, the pair stalls once
  task automatic t_one_cycle(input logic [2:0] cop, input logic [2:0] ra, input logic [2:0] rb);
    logic [31:0] nxt, younger;
    @(negedge clk);
    flush_q = 1'b0;
    younger = mk(7'd0, cop, ra, rb, 16'h0004);
    idex_q = mk(7'd0, 3'd2, 3'd0, 3'd3, 16'h0001);
    ifid_q = younger;
    #1;
    chk("R9 first cycle stall", {31'd0, stall}, 32'd1);
    nxt = idex_instr_next;
    @(posedge clk);
    idex_q = nxt;
    if (!ifid_hold) ifid_q = NOOP_W;
    @(negedge clk);
    #1;
    chk("R9 second cycle clear", {31'd0, stall}, 32'd0);
    chk("R9 latch kept", ifid_q, younger);
    chk("R9 consumer passes", idex_instr_next, younger);
  endtask

  // R7: flush with a live hazard
  task automatic t_flush_hazard();
    flush_q = 1'b1;
    idex_q = mk(7'd0, 3'd2, 3'd0, 3'd4, 16'd0);
    ifid_q = mk(7'd0, 3'd4, 3'd4, 3'd4, 16'd2);
    #1;
    chk("R7 raw stall kept", {31'd0, stall}, 32'd1);
    chk("R7 holds dropped", {30'd0, pc_hold, ifid_hold}, 32'd0);
    chk("R7 bubble", idex_instr_next, NOOP_W);
    flush_q = 1'b0;
    #1;
    chk("R5 holds back", {30'd0, pc_hold, ifid_hold}, 32'd3);
  endtask

  // R3: second field of a store ignored even when it matches
  task automatic t_store_data();
    flush_q = 1'b0;
    idex_q = mk(7'd0, 3'd2, 3'd0, 3'd5, 16'd0);
    ifid_q = mk(7'd0, 3'd3, 3'd1, 3'd5, 16'd0);
    #1;
    chk("R3 store data no stall", {31'd0, stall}, 32'd0);
    chk("R3 store passes", idex_instr_next, ifid_q);
    ifid_q = mk(7'd0, 3'd3, 3'd5, 3'd1, 16'd0);
    #1;
    chk("R3 store base stall", {31'd0, stall}, 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_store_data();
    t_flush_hazard();
    t_ignored_bits();
    t_one_cycle(3'd0, 3'd3, 3'd1);
    t_one_cycle(3'd4, 3'd2, 3'd3);
    t_one_cycle(3'd2, 3'd3, 3'd7);
    t_sweep();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule